// File: doc/BRIEF.md
# Open-Drain Two-Wire Register Master with Clock Stretching

This block runs single-register transactions on a two-wire open-drain bus (I2C). A write transaction sends a START, the 7-bit device address with the write bit, a register pointer byte, one data byte and a STOP. A read transaction sends the same address and pointer. It then issues a repeated START without a STOP, resends the address with the read bit, receives one byte, answers it with a NAK and ends with a STOP. The user loads the device address, pointer, write data and a read select in one `cmd_valid_i` cycle. The block reports completion through a one-cycle `done_o` pulse, together with `nak_o`, `timeout_o` and `rdata_o`.

Both lines are driven open-drain. A high output on `scl_oe_o` or `sda_oe_o` pulls that line low, and a low output releases it. The clock line is treated as a wired-AND. The low period lasts `low_cyc_i + 1` clocks of the master pulling the line. After that the master releases SCL and waits until the synchronized line actually reads high. Only then does it count the high period of `high_cyc_i + 1` clocks. Any slave can therefore lengthen a low period, or halt the bus after a byte, simply by holding SCL low. A watchdog limits how long the master waits for SCL to rise.

Top module: `i2c_sync_master`

## Requirements
- R1: Out of reset both line drivers are released (`scl_oe_o` = 0, `sda_oe_o` = 0), `busy_o` = 0 and `done_o` = 0.
- R2: A write command puts these on the bus: START, the address byte `{dev,0}`, the pointer byte, the data byte and STOP. Every byte goes MSB first, and the 9th clock of each byte is the acknowledge slot. When the slave acknowledges every byte, `done_o` pulses with `nak_o` = 0.
- R3: A read command sends START, `{dev,0}` and the pointer. It then sends a repeated START (no STOP in between) and `{dev,1}`, and clocks in one byte MSB first. SDA is left high on that byte's 9th clock (NAK), and a STOP follows. The byte appears on `rdata_o` when `done_o` pulses.
- R4: If the acknowledge slot of any transmitted byte reads high, the master sets `nak_o`, sends no further byte, issues a STOP and pulses `done_o`.
- R5: During data and acknowledge bits, SDA changes only while SCL is pulled low. SDA changes while SCL is high only for START, repeated START and STOP.
- R6: The high period is counted from the moment the synchronized SCL reads high, not from release. A slave holding SCL low therefore lengthens the low period and leaves the high period unchanged.
- R7: A slave holding SCL low after the 9th clock of a byte halts the transfer, and the transaction still completes once SCL is released.
- R8: If SCL stays low for more than `stretch_lim_i` clocks while the master waits for it to rise, the transaction is aborted. Both lines are released, `timeout_o` is set and `done_o` pulses. A later command runs normally.
- R9: Each SCL low period lasts at least `low_cyc_i + 1` clocks (`low_cyc_i` must be at least 2).
- R10: `done_o` is a single-cycle pulse. `busy_o` is high from the cycle after a command is accepted until `done_o`, and is low during `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| low_cyc_i | input | DIV_W | SCL low period minus one, in clocks |
| high_cyc_i | input | DIV_W | SCL high period minus one, in clocks |
| stretch_lim_i | input | TO_W | Longest wait for SCL to rise before abort |
| cmd_valid_i | input | 1 | Start a transaction (taken when idle) |
| cmd_rd_i | input | 1 | 1 = register read, 0 = register write |
| cmd_dev_i | input | 7 | Device address |
| cmd_reg_i | input | 8 | Register pointer |
| cmd_wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| nak_o | output | 1 | Last transaction saw a missing acknowledge |
| timeout_o | output | 1 | Last transaction aborted on SCL timeout |
| rdata_o | output | 8 | Byte returned by the last read |
| scl_i | input | 1 | SCL bus level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA bus level |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
Two things can land on the same clock edge. One is the master's own release of SCL at the end of its low count. The other is a slave's stretch, which keeps the line low past that point. The bench's slave model holds SCL on every falling edge for longer than the master's low period, and for longer still after each 9th clock. A per-clock monitor measures every low and high pulse on the wired-AND line. Low pulses must be at least the stretch length. High pulses that carry a data bit must stay within one clock of the unstretched high length, which shows the high count began only when the line was seen high.

// File: rtl/i2c_sync_pkg.sv
package i2c_sync_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;
  localparam int BIT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_LOW, ST_WAIT, ST_HIGH,
    ST_RS_LOW, ST_RS_WAIT, ST_RS_HIGH,
    ST_SP_LOW, ST_SP_WAIT, ST_SP_HIGH, ST_SP_END
  } state_e;

  typedef enum logic [2:0] {
    PH_ADDR_W, PH_REG, PH_WDATA, PH_ADDR_R, PH_RDATA
  } phase_e;
endpackage

// File: rtl/i2c_sync_sync.sv
module i2c_sync_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) st_q <= '1;
      else         st_q <= d_i;
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) st_q <= '1;
      else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/i2c_sync_timer.sv
module i2c_sync_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  assign exp_o = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!exp_o) cnt_q <= cnt_q + 1'b1;

  // R9: an expired count stays put until the phase advances
  a_r9_tmr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_o && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/i2c_sync_wd.sv
module i2c_sync_wd #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         trip_o
);
  logic [W-1:0] cnt_q;

  assign trip_o = run_i && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q != {W{1'b1}}) cnt_q <= cnt_q + 1'b1;

  // R8: the stretch count restarts for every wait
  a_r8_wd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_sync_master.sv
module i2c_sync_master
  import i2c_sync_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  low_cyc_i,
  input  logic [DIV_W-1:0]  high_cyc_i,
  input  logic [TO_W-1:0]   stretch_lim_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_rd_i,
  input  logic [DEV_W-1:0]  cmd_dev_i,
  input  logic [BYTE_W-1:0] cmd_reg_i,
  input  logic [BYTE_W-1:0] cmd_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              nak_o,
  output logic              timeout_o,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              scl_i,
  output logic              scl_oe_o,
  input  logic              sda_i,
  output logic              sda_oe_o
);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

  state_e              state_q;
  phase_e              phase_q;
  logic [BIT_W-1:0]    bit_q;
  logic [BYTE_W-1:0]   shift_q, rdata_q, reg_q, wdata_q;
  logic [DEV_W-1:0]    dev_q;
  logic                rd_q, scl_oe_q, sda_oe_q, nak_q, to_q, done_q;

  logic scl_s, sda_s;
  logic [1:0] sync_q;

  i2c_sync_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(sync_q));
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  logic timed_st, wait_st, low_st, tmr_exp, wd_trip, adv;
  logic [DIV_W-1:0] tmr_lim;

  assign low_st   = state_q inside {ST_LOW, ST_RS_LOW, ST_SP_LOW};
  assign wait_st  = state_q inside {ST_WAIT, ST_RS_WAIT, ST_SP_WAIT};
  assign timed_st = !wait_st && (state_q != ST_IDLE);
  assign tmr_lim  = low_st ? low_cyc_i : high_cyc_i;
  assign adv = (state_q == ST_IDLE && cmd_valid_i) || (timed_st && tmr_exp) ||
               (wait_st && (scl_s || wd_trip));

  i2c_sync_timer #(.W(DIV_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(adv), .lim_i(tmr_lim), .exp_o(tmr_exp));

  i2c_sync_wd #(.W(TO_W)) u_wd (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(wait_st), .lim_i(stretch_lim_i),
    .trip_o(wd_trip));

  logic is_tx, sda_next;
  assign is_tx    = (phase_q != PH_RDATA);
  assign sda_next = is_tx && (bit_q != ACK_SLOT) && !shift_q[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR_W;
      bit_q    <= '0;
      shift_q  <= '0;
      rdata_q  <= '0;
      reg_q    <= '0;
      wdata_q  <= '0;
      dev_q    <= '0;
      rd_q     <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      nak_q    <= 1'b0;
      to_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wait_st && wd_trip) begin
        scl_oe_q <= 1'b0;
        sda_oe_q <= 1'b0;
        to_q     <= 1'b1;
        done_q   <= 1'b1;
        state_q  <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (cmd_valid_i) begin
            dev_q    <= cmd_dev_i;
            reg_q    <= cmd_reg_i;
            wdata_q  <= cmd_wdata_i;
            rd_q     <= cmd_rd_i;
            phase_q  <= PH_ADDR_W;
            shift_q  <= {cmd_dev_i, 1'b0};
            bit_q    <= '0;
            nak_q    <= 1'b0;
            to_q     <= 1'b0;
            sda_oe_q <= 1'b1;           // START: SDA falls, SCL high
            state_q  <= ST_START;
          end
          ST_START: if (tmr_exp) begin
            scl_oe_q <= 1'b1;
            state_q  <= ST_LOW;
          end
          ST_LOW: begin
            sda_oe_q <= sda_next;       // SCL already low here
            if (tmr_exp) begin
              scl_oe_q <= 1'b0;
              state_q  <= ST_WAIT;
            end
          end
          ST_WAIT: if (scl_s) state_q <= ST_HIGH;
          ST_HIGH: if (tmr_exp) begin
            scl_oe_q <= 1'b1;
            state_q  <= ST_LOW;
            if (bit_q != ACK_SLOT) begin
              bit_q   <= bit_q + 1'b1;
              shift_q <= is_tx ? {shift_q[BYTE_W-2:0], 1'b0}
                               : {shift_q[BYTE_W-2:0], sda_s};
            end else begin
              bit_q <= '0;
              if (is_tx && sda_s) begin
                nak_q   <= 1'b1;
                state_q <= ST_SP_LOW;
              end else begin
                unique case (phase_q)
                  PH_ADDR_W: begin phase_q <= PH_REG; shift_q <= reg_q; end
                  PH_REG: if (rd_q) state_q <= ST_RS_LOW;
                          else begin phase_q <= PH_WDATA; shift_q <= wdata_q; end
                  PH_WDATA: state_q <= ST_SP_LOW;
                  PH_ADDR_R: begin phase_q <= PH_RDATA; shift_q <= '0; end
                  PH_RDATA: begin rdata_q <= shift_q; state_q <= ST_SP_LOW; end
                  default: state_q <= ST_SP_LOW;
                endcase
              end
            end
          end
          ST_RS_LOW: begin
            sda_oe_q <= 1'b0;
            if (tmr_exp) begin
              scl_oe_q <= 1'b0;
              state_q  <= ST_RS_WAIT;
            end
          end
          ST_RS_WAIT: if (scl_s) state_q <= ST_RS_HIGH;
          ST_RS_HIGH: if (tmr_exp) begin
            sda_oe_q <= 1'b1;           // repeated START
            phase_q  <= PH_ADDR_R;
            shift_q  <= {dev_q, 1'b1};
            state_q  <= ST_START;
          end
          ST_SP_LOW: begin
            sda_oe_q <= 1'b1;
            if (tmr_exp) begin
              scl_oe_q <= 1'b0;
              state_q  <= ST_SP_WAIT;
            end
          end
          ST_SP_WAIT: if (scl_s) state_q <= ST_SP_HIGH;
          ST_SP_HIGH: if (tmr_exp) begin
            sda_oe_q <= 1'b0;           // STOP: SDA rises, SCL high
            state_q  <= ST_SP_END;
          end
          ST_SP_END: if (tmr_exp) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign nak_o     = nak_q;
  assign timeout_o = to_q;
  assign rdata_o   = rdata_q;
  assign scl_oe_o  = scl_oe_q;
  assign sda_oe_o  = sda_oe_q;

  logic bit_phase;
  assign bit_phase = state_q inside {ST_LOW, ST_WAIT, ST_HIGH};

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r5_sda_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_phase && !scl_oe_o) |-> $stable(sda_oe_o));
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> (!scl_oe_o && !sda_oe_o && !nak_o));
endmodule

// File: tb/tb_i2c_sync_master.sv
module tb_i2c_sync_master;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  low_cyc = 8'd6, high_cyc = 8'd5;
  logic [15:0] lim = 16'd200;
  logic        cmd_valid = 1'b0, cmd_rd = 1'b0;
  logic [6:0]  cmd_dev = '0;
  logic [7:0]  cmd_reg = '0, cmd_wdata = '0;
  logic        busy, done, nak, tmo, scl_oe, sda_oe;
  logic [7:0]  rdata;
  logic        slv_scl_hold = 1'b0, slv_sda_pull = 1'b0;
  wire         scl_bus = !(scl_oe | slv_scl_hold);
  wire         sda_bus = !(sda_oe | slv_sda_pull);

  i2c_sync_master dut (
    .clk_i(clk), .rst_ni(rst_n), .low_cyc_i(low_cyc), .high_cyc_i(high_cyc),
    .stretch_lim_i(lim), .cmd_valid_i(cmd_valid), .cmd_rd_i(cmd_rd),
    .cmd_dev_i(cmd_dev), .cmd_reg_i(cmd_reg), .cmd_wdata_i(cmd_wdata),
    .busy_o(busy), .done_o(done), .nak_o(nak), .timeout_o(tmo), .rdata_o(rdata),
    .scl_i(scl_bus), .scl_oe_o(scl_oe), .sda_i(sda_bus), .sda_oe_o(sda_oe));

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // slave configuration, written only by the stimulus
  int  stretch_each = 0, stretch_byte = 0, mon_epoch = 0;
  bit  hold_forever = 1'b0;

  // behavioural slave and line monitor, one pass per clock on the falling edge
  logic [7:0] regs [16];
  logic [7:0] s_sh = '0, s_ptr = '0;
  int  s_cnt = 0, s_idx = 0, hold_cnt = 0, starts = 0, stops = 0;
  bit  s_active = 0, s_tx = 0, s_rw = 0, s_ack = 0, s_mack = 0;
  bit  p_scl = 1, p_sda = 1;
  int  hi_run = 0, lo_run = 0, min_lo = 0, max_lo = 0, min_hi = 0, hi_bad = 0;
  int  seen_epoch = 0;
  bit  sda_moved = 0;

  always @(negedge clk) begin
    bit scl_now, sda_now;
    scl_now = scl_bus;
    sda_now = sda_bus;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] = 8'hC0 + 8'(i);
      s_active = 0; s_cnt = 0; hold_cnt = 0;
      slv_scl_hold = 0; slv_sda_pull = 0;
      p_scl = 1; p_sda = 1;
    end else begin
      if (seen_epoch != mon_epoch) begin
        seen_epoch = mon_epoch;
        min_lo = 1 << 30; max_lo = 0; min_hi = 1 << 30; hi_bad = 0;
        hi_run = 0; lo_run = 0;
      end
      // pulse measurement (R6, R7, R9)
      if (scl_now) begin
        if (!p_scl) begin hi_run = 0; sda_moved = 0; end
        hi_run++;
        if (sda_now != p_sda) sda_moved = 1;
      end else begin
        if (p_scl) begin
          if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
          if (hi_run > 0 && !sda_moved &&
              (hi_run < int'(high_cyc) + 3 || hi_run > int'(high_cyc) + 5)) hi_bad++;
          lo_run = 0;
        end
        lo_run++;
      end
      if (!p_scl && scl_now && lo_run > 0) begin
        if (lo_run < min_lo) min_lo = lo_run;
        if (lo_run > max_lo) max_lo = lo_run;
      end
      // protocol decode
      if (p_scl && scl_now && p_sda && !sda_now) begin
        starts++; s_active = 1; s_cnt = 0; s_idx = 0; s_tx = 0; slv_sda_pull = 0;
      end else if (p_scl && scl_now && !p_sda && sda_now) begin
        stops++; s_active = 0; slv_sda_pull = 0;
      end else if (s_active && !p_scl && scl_now) begin
        if (s_cnt < 8) begin
          if (!s_tx) s_sh = {s_sh[6:0], sda_now};
        end else s_mack = sda_now;
        s_cnt++;
      end else if (p_scl && !scl_now) begin
        hold_cnt = stretch_each + ((s_cnt == 9) ? stretch_byte : 0);
        if (s_active) begin
          if (s_cnt == 8) begin
            if (!s_tx) begin
              if (s_idx == 0) begin s_ack = (s_sh[7:1] == SLV); s_rw = s_sh[0]; end
              else if (s_idx == 1) begin s_ptr = s_sh; s_ack = 1; end
              else begin regs[s_ptr[3:0]] = s_sh; s_ack = 1; end
              slv_sda_pull = s_ack;
            end else slv_sda_pull = 0;
          end else if (s_cnt == 9) begin
            s_cnt = 0; slv_sda_pull = 0;
            if (s_tx || !s_ack) s_active = 0;
            else begin
              if (s_idx == 0 && s_rw) begin
                s_tx = 1; s_sh = regs[s_ptr[3:0]]; slv_sda_pull = !s_sh[7];
              end
              s_idx++;
            end
          end else if (s_tx && s_cnt >= 1 && s_cnt <= 7) begin
            slv_sda_pull = !s_sh[7 - s_cnt];
          end
        end
      end
      if (hold_forever) slv_scl_hold = 1;
      else if (hold_cnt > 0) begin slv_scl_hold = 1; hold_cnt--; end
      else slv_scl_hold = 0;
      p_scl = scl_now; p_sda = sda_now;
    end
  end

  bit r_nak, r_to, r_busy, r_pulse_ok;
  logic [7:0] r_rdata;
  int st0, sp0;

  task automatic run(input bit rd, input logic [6:0] dv, input logic [7:0] rg,
                     input logic [7:0] wd);
    int n;
    mon_epoch++;
    st0 = starts; sp0 = stops;
    @(negedge clk);
    cmd_valid = 1; cmd_rd = rd; cmd_dev = dv; cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    n = 0;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    r_nak = nak; r_to = tmo; r_rdata = rdata; r_busy = busy;
    @(negedge clk);
    r_pulse_ok = !done;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R10 watchdog expired act=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", int'({scl_oe, sda_oe}), 0);
    chk(busy == 0 && done == 0, "R1 idle flags", int'({busy, done}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // plain write
    run(0, SLV, 8'h03, 8'hA5);
    chk(r_pulse_ok && !r_busy, "R10 single done pulse", int'(r_busy), 0);
    chk(r_nak == 0 && r_to == 0, "R2 write acked", int'({r_nak, r_to}), 0);
    chk(regs[3] == 8'hA5, "R2 data at pointer", int'(regs[3]), 'hA5);
    chk(starts - st0 == 1 && stops - sp0 == 1, "R5 write start/stop count",
        (starts - st0) * 10 + stops - sp0, 11);
    chk(min_lo >= int'(low_cyc) + 1, "R9 low length", min_lo, int'(low_cyc) + 1);
    chk(hi_bad == 0, "R6 high length plain", hi_bad, 0);

    // plain read
    run(1, SLV, 8'h03, 8'h00);
    chk(r_rdata == 8'hA5, "R3 read data", int'(r_rdata), 'hA5);
    chk(starts - st0 == 2 && stops - sp0 == 1, "R3 repeated start no stop",
        (starts - st0) * 10 + stops - sp0, 21);
    chk(s_mack == 1, "R3 master NAK on read byte", int'(s_mack), 1);
    chk(r_nak == 0, "R3 no error", int'(r_nak), 0);

    // read with every low period stretched
    stretch_each = 20;
    run(1, SLV, 8'h07, 8'h00);
    chk(r_rdata == 8'hC7, "R3 read stretched", int'(r_rdata), 'hC7);
    chk(min_lo >= 20, "R6 low stretched", min_lo, 20);
    chk(hi_bad == 0, "R6 high unchanged under stretch", hi_bad, 0);
    chk(min_hi >= int'(high_cyc) + 3, "R6 high minimum", min_hi, int'(high_cyc) + 3);

    // halt after every byte
    stretch_byte = 120;
    run(0, SLV, 8'h09, 8'h3C);
    chk(max_lo >= 140, "R7 hold after byte", max_lo, 140);
    chk(regs[9] == 8'h3C && r_to == 0, "R7 write completes", int'(regs[9]), 'h3C);
    stretch_each = 0; stretch_byte = 0;

    // missing acknowledge
    run(0, 7'h11, 8'h03, 8'h00);
    chk(r_nak == 1 && r_to == 0, "R4 nak flagged", int'({r_nak, r_to}), 2);
    chk(stops - sp0 == 1, "R4 stop after nak", stops - sp0, 1);
    run(1, SLV, 8'h03, 8'h00);
    chk(r_rdata == 8'hA5 && r_nak == 0, "R4 register untouched", int'(r_rdata), 'hA5);

    // stuck clock line
    hold_forever = 1;
    run(0, SLV, 8'h05, 8'h77);
    chk(r_to == 1 && r_nak == 0, "R8 timeout flagged", int'({r_to, r_nak}), 2);
    chk(scl_oe == 0 && sda_oe == 0, "R8 lines released", int'({scl_oe, sda_oe}), 0);
    hold_forever = 0;
    repeat (10) @(negedge clk);
    run(0, SLV, 8'h05, 8'h5E);
    chk(r_to == 0 && regs[5] == 8'h5E, "R8 recovery write", int'(regs[5]), 'h5E);
    run(1, SLV, 8'h05, 8'h00);
    chk(r_rdata == 8'h5E, "R8 recovery read", int'(r_rdata), 'h5E);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule